// File: doc/BRIEF.md
# TDM Multi-Stream Slot Transmitter

This block puts five sample streams (voltage sense, current sense, a SAR measurement word, processed audio and a status byte) onto one shared serial data line of a TDM bus. It runs on a fast system clock. The bit clock and the frame-sync line come in as sampled levels. The block finds the chosen bit-clock edge, counts bit periods from the start of each frame, and at each launch edge chooses the stream that owns the current bit. It then registers that bit onto the data output.

Each stream has its own slot index, counted in 8-bit slots, and its own enable. SAR and audio words can be 16 or 24 bits long. Voltage and current words are 16 bits, 8 bits, or a packed pair of 12-bit values spread over three slots. Bits that no stream owns are driven low, or the line is released. When the line is released, a weak hold request can be raised for one bit period, for half of one, or for as long as the line stays released. The hold request goes to the pad keeper.

Top module: `tdm_stream_tx`

## Requirements
- R1: With `launch_fall` = 0, outputs change only at rising edges of `bit_clk`. With `launch_fall` = 1, they change only at falling edges. The other edge is called the opposite edge.
- R2: A frame starts at the first launch edge where `frame_sync` is 1, if it was 0 at the previous launch edge. That bit period has bit count 0. Data position p = count − `bit_off`. Counts below `bit_off` belong to no stream.
- R3: A stream whose slot is s owns positions 8·s up to 8·s + len − 1. It sends its word MSB first, one bit per launch edge. SAR and audio have len = 16 (their bits 23..8) when the length bit is 0, and len = 24 when it is 1. Status has len = 8.
- R4: `iv_mode` = 00 or 11 sends the full 16-bit voltage and current words. `iv_mode` = 01 sends only bits 15..8 of each, in one slot.
- R5: `iv_mode` = 10 sends 24 bits starting at the voltage slot: voltage bits 15..4, then current bits 15..4. In this mode the current slot and the current enable have no effect. The packed word needs `v_en` = 1.
- R6: When enabled streams claim the same position, the winner is chosen in this order: voltage, current, SAR, audio, status.
- R7: With `fill_hiz` = 0, an unowned bit drives `sdout` = 0 with `sdout_oe` = 1, and `hold_drv` = 0.
- R8: With `fill_hiz` = 1, an unowned bit sets `sdout_oe` = 0 at that launch edge, and `sdout` keeps its last value. The launch edge right after the last owned bit therefore releases the line.
- R9: With `hold_perm` = 0 and `hold_en` = 1, `hold_drv` is 1 only for the released bit period that directly follows a driven bit.
- R10: With `hold_half` = 1 and `hold_perm` = 0, that `hold_drv` pulse ends at the next opposite edge.
- R11: With `hold_perm` = 1 and `hold_en` = 1, `hold_drv` is 1 for every released bit. With `hold_en` = 0, `hold_drv` stays 0.
- R12: A new frame start sets the count back to 0. A word that runs past the end of the frame is cut off, and nothing of it appears in the next frame.
- R13: After reset, `sdout`, `sdout_oe` and `hold_drv` are 0, and the bit count sits at its saturated idle value, where no stream owns a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_clk | input | 1 | Bit clock level, sampled by clk |
| frame_sync | input | 1 | Frame sync level |
| launch_fall | input | 1 | 1: launch on falling bit-clock edge |
| bit_off | input | 3 | Bit periods from frame start to slot 0 |
| fill_hiz | input | 1 | 1: release unowned bits, 0: drive zero |
| hold_en | input | 1 | Keeper request enable |
| hold_perm | input | 1 | 1: hold for the whole released time |
| hold_half | input | 1 | 1: one-bit hold ends at the opposite edge |
| iv_mode | input | 2 | Sense word format |
| v_en | input | 1 | Voltage stream enable |
| v_slot | input | 6 | Voltage slot index |
| v_data | input | 16 | Voltage sample |
| i_en | input | 1 | Current stream enable |
| i_slot | input | 6 | Current slot index |
| i_data | input | 16 | Current sample |
| sar_en | input | 1 | SAR stream enable |
| sar_slot | input | 6 | SAR slot index |
| sar_len24 | input | 1 | SAR word length 24 (1) or 16 (0) |
| sar_data | input | 24 | SAR word |
| aud_en | input | 1 | Audio stream enable |
| aud_slot | input | 6 | Audio slot index |
| aud_len24 | input | 1 | Audio word length 24 (1) or 16 (0) |
| aud_data | input | 24 | Audio word |
| st_en | input | 1 | Status stream enable |
| st_slot | input | 6 | Status slot index |
| st_data | input | 8 | Status byte |
| sdout | output | 1 | Serial data |
| sdout_oe | output | 1 | Output enable for the tri-state pad |
| hold_drv | output | 1 | Weak keeper request |

## Verification
The hardest case to reach is the keeper pulse in the released state. It appears only when an owned word ends while `fill_hiz` = 1, and its length depends on whether an opposite bit-clock edge falls inside the following period. That opposite edge is missing when the launch edge has just been switched. The stimulus therefore changes the launch edge, the fill mode and the hold options between frames. Directed frames place words so that they end right before released gaps and past the frame boundary. Random frames then vary frame length, sync width, offset and slot positions.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
    localparam int NSTREAM = 5;
    localparam int WORD_W  = 24;
    localparam int SENSE_W = 16;
    localparam int PACK_W  = WORD_W / 2;
    localparam int STAT_W  = 8;

    typedef enum logic [1:0] {
        IV_FULL  = 2'b00,
        IV_MSB8  = 2'b01,
        IV_PACK  = 2'b10,
        IV_FULL2 = 2'b11
    } iv_mode_e;

    typedef struct packed {
        logic sd;
        logic oe;
        logic hold;
    } line_t;
endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_clk,
    input  logic             frame_sync,
    input  logic             launch_fall,
    output logic             launch,
    output logic             opp,
    output logic [CNT_W-1:0] cnt_cur
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             clk_lvl;
        logic             fs_last;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tm_d, tm_q;
    logic rise, fall, fs_start;

    always_comb begin
        tm_d     = tm_q;
        rise     = bit_clk & ~tm_q.clk_lvl;
        fall     = ~bit_clk & tm_q.clk_lvl;
        launch   = launch_fall ? fall : rise;
        opp      = launch_fall ? rise : fall;
        fs_start = frame_sync & ~tm_q.fs_last;
        if (fs_start)
            cnt_cur = '0;
        else if (tm_q.cnt == CNT_MAX)
            cnt_cur = CNT_MAX;
        else
            cnt_cur = tm_q.cnt + 1'b1;
        tm_d.clk_lvl = bit_clk;
        if (launch) begin
            tm_d.fs_last = frame_sync;
            tm_d.cnt     = cnt_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q.clk_lvl <= 1'b0;
            tm_q.fs_last <= 1'b0;
            tm_q.cnt     <= CNT_MAX;
        end else begin
            tm_q <= tm_d;
        end
    end
endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map
    import tdm_tx_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int SLOT_W    = 6,
    parameter int SLOT_BITS = 8,
    parameter int OFF_W     = 3
) (
    input  logic [CNT_W-1:0]   cnt,
    input  logic [OFF_W-1:0]   bit_off,
    input  logic [1:0]         iv_mode,
    input  logic               v_en,
    input  logic [SLOT_W-1:0]  v_slot,
    input  logic [SENSE_W-1:0] v_data,
    input  logic               i_en,
    input  logic [SLOT_W-1:0]  i_slot,
    input  logic [SENSE_W-1:0] i_data,
    input  logic               sar_en,
    input  logic [SLOT_W-1:0]  sar_slot,
    input  logic               sar_len24,
    input  logic [WORD_W-1:0]  sar_data,
    input  logic               aud_en,
    input  logic [SLOT_W-1:0]  aud_slot,
    input  logic               aud_len24,
    input  logic [WORD_W-1:0]  aud_data,
    input  logic               st_en,
    input  logic [SLOT_W-1:0]  st_slot,
    input  logic [STAT_W-1:0]  st_data,
    output logic               hit,
    output logic               bit_val
);
    localparam int LSB_W = $clog2(SLOT_BITS);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(SENSE_W);
    localparam logic [CNT_W-1:0] LEN_WORD = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LEN_BYTE = CNT_W'(SLOT_BITS);

    logic               en   [NSTREAM];
    logic [SLOT_W-1:0]  slot [NSTREAM];
    logic [CNT_W-1:0]   len  [NSTREAM];
    logic [WORD_W-1:0]  word [NSTREAM];
    logic [CNT_W-1:0]   start[NSTREAM];
    logic [CNT_W-1:0]   rel  [NSTREAM];
    logic [IDX_W-1:0]   ix   [NSTREAM];
    logic               hit_k[NSTREAM];
    logic               bit_k[NSTREAM];
    logic               pos_ok;
    logic [CNT_W-1:0]   pos;
    logic               packed_iv;

    always_comb begin
        pos_ok    = cnt >= CNT_W'(bit_off);
        pos       = cnt - CNT_W'(bit_off);
        packed_iv = (iv_mode == IV_PACK);

        en[0]   = v_en;
        slot[0] = v_slot;
        word[0] = packed_iv ? {v_data[SENSE_W-1 -: PACK_W], i_data[SENSE_W-1 -: PACK_W]}
                            : {v_data, {(WORD_W-SENSE_W){1'b0}}};
        len[0]  = packed_iv ? LEN_WORD : ((iv_mode == IV_MSB8) ? LEN_BYTE : LEN_FULL);

        en[1]   = i_en & ~packed_iv;
        slot[1] = i_slot;
        word[1] = {i_data, {(WORD_W-SENSE_W){1'b0}}};
        len[1]  = (iv_mode == IV_MSB8) ? LEN_BYTE : LEN_FULL;

        en[2]   = sar_en;
        slot[2] = sar_slot;
        word[2] = sar_data;
        len[2]  = sar_len24 ? LEN_WORD : LEN_FULL;

        en[3]   = aud_en;
        slot[3] = aud_slot;
        word[3] = aud_data;
        len[3]  = aud_len24 ? LEN_WORD : LEN_FULL;

        en[4]   = st_en;
        slot[4] = st_slot;
        word[4] = {st_data, {(WORD_W-STAT_W){1'b0}}};
        len[4]  = LEN_BYTE;
    end

    for (genvar k = 0; k < NSTREAM; k++) begin : g_stream
        assign start[k] = CNT_W'(slot[k]) << LSB_W;
        assign rel[k]   = pos - start[k];
        assign hit_k[k] = en[k] && pos_ok && (pos >= start[k]) && (rel[k] < len[k]);
        assign ix[k]    = IDX_W'(WORD_W - 1) - rel[k][IDX_W-1:0];
        assign bit_k[k] = word[k][ix[k]];
    end

    always_comb begin
        hit     = 1'b0;
        bit_val = 1'b0;
        for (int k = NSTREAM - 1; k >= 0; k--) begin
            if (hit_k[k]) begin
                hit     = 1'b1;
                bit_val = bit_k[k];
            end
        end
    end
endmodule

// File: rtl/tdm_line_drv.sv
module tdm_line_drv
    import tdm_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic opp,
    input  logic hit,
    input  logic bit_val,
    input  logic fill_hiz,
    input  logic hold_en,
    input  logic hold_perm,
    input  logic hold_half,
    output logic sdout,
    output logic sdout_oe,
    output logic hold_drv
);
    line_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (launch) begin
            if (hit) begin
                ln_d.sd   = bit_val;
                ln_d.oe   = 1'b1;
                ln_d.hold = 1'b0;
            end else if (!fill_hiz) begin
                ln_d.sd   = 1'b0;
                ln_d.oe   = 1'b1;
                ln_d.hold = 1'b0;
            end else begin
                ln_d.oe   = 1'b0;
                ln_d.hold = hold_en & (hold_perm | ln_q.oe);
            end
        end else if (opp && hold_half && !hold_perm) begin
            ln_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ln_q <= '0;
        else
            ln_q <= ln_d;
    end

    assign sdout    = ln_q.sd;
    assign sdout_oe = ln_q.oe;
    assign hold_drv = ln_q.hold;
endmodule

// File: rtl/tdm_stream_tx.sv
module tdm_stream_tx
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_W    = 6,
    parameter int SLOT_BITS = 8,
    parameter int OFF_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_clk,
    input  logic               frame_sync,
    input  logic               launch_fall,
    input  logic [OFF_W-1:0]   bit_off,
    input  logic               fill_hiz,
    input  logic               hold_en,
    input  logic               hold_perm,
    input  logic               hold_half,
    input  logic [1:0]         iv_mode,
    input  logic               v_en,
    input  logic [SLOT_W-1:0]  v_slot,
    input  logic [SENSE_W-1:0] v_data,
    input  logic               i_en,
    input  logic [SLOT_W-1:0]  i_slot,
    input  logic [SENSE_W-1:0] i_data,
    input  logic               sar_en,
    input  logic [SLOT_W-1:0]  sar_slot,
    input  logic               sar_len24,
    input  logic [WORD_W-1:0]  sar_data,
    input  logic               aud_en,
    input  logic [SLOT_W-1:0]  aud_slot,
    input  logic               aud_len24,
    input  logic [WORD_W-1:0]  aud_data,
    input  logic               st_en,
    input  logic [SLOT_W-1:0]  st_slot,
    input  logic [STAT_W-1:0]  st_data,
    output logic               sdout,
    output logic               sdout_oe,
    output logic               hold_drv
);
    localparam int CNT_W = SLOT_W + $clog2(SLOT_BITS) + 1;

    logic             launch, opp, hit, bit_val;
    logic [CNT_W-1:0] cnt_cur;

    tdm_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_sync(frame_sync),
        .launch_fall(launch_fall), .launch(launch), .opp(opp), .cnt_cur(cnt_cur)
    );

    tdm_slot_map #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .SLOT_BITS(SLOT_BITS), .OFF_W(OFF_W)) u_map (
        .cnt(cnt_cur), .bit_off(bit_off), .iv_mode(iv_mode),
        .v_en(v_en), .v_slot(v_slot), .v_data(v_data),
        .i_en(i_en), .i_slot(i_slot), .i_data(i_data),
        .sar_en(sar_en), .sar_slot(sar_slot), .sar_len24(sar_len24), .sar_data(sar_data),
        .aud_en(aud_en), .aud_slot(aud_slot), .aud_len24(aud_len24), .aud_data(aud_data),
        .st_en(st_en), .st_slot(st_slot), .st_data(st_data),
        .hit(hit), .bit_val(bit_val)
    );

    tdm_line_drv u_line (
        .clk(clk), .rst_n(rst_n), .launch(launch), .opp(opp), .hit(hit), .bit_val(bit_val),
        .fill_hiz(fill_hiz), .hold_en(hold_en), .hold_perm(hold_perm), .hold_half(hold_half),
        .sdout(sdout), .sdout_oe(sdout_oe), .hold_drv(hold_drv)
    );
endmodule

// File: rtl/tdm_stream_tx_chk.sv
module tdm_stream_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic launch,
    input logic opp,
    input logic hit,
    input logic fill_hiz,
    input logic hold_en,
    input logic hold_perm,
    input logic hold_half,
    input logic sdout,
    input logic sdout_oe,
    input logic hold_drv
);
    AST_OE_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdout_oe) |-> $past(launch)); // R1
    AST_SD_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdout) |-> $past(launch)); // R1
    AST_ZERO_FILL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        launch && !fill_hiz |=> sdout_oe); // R7
    AST_HOLD_ONE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        launch && !hold_perm && hold_drv |=> !hold_drv); // R9
    AST_HOLD_HALF_END: assert property (@(posedge clk) disable iff (!rst_n)
        opp && hold_half && !hold_perm |=> !hold_drv); // R10
    AST_HOLD_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        launch && !hit && fill_hiz && hold_en && hold_perm |=> hold_drv && !sdout_oe); // R11
endmodule

bind tdm_stream_tx tdm_stream_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .opp(opp), .hit(hit),
    .fill_hiz(fill_hiz), .hold_en(hold_en), .hold_perm(hold_perm), .hold_half(hold_half),
    .sdout(sdout), .sdout_oe(sdout_oe), .hold_drv(hold_drv)
);

// File: tb/tdm_stream_tx_test.sv
module tdm_stream_tx_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_clk = 1'b0, frame_sync = 1'b0, launch_fall = 1'b0;
    logic [2:0] bit_off = 3'd0;
    logic fill_hiz = 1'b0, hold_en = 1'b0, hold_perm = 1'b0, hold_half = 1'b0;
    logic [1:0] iv_mode = 2'b00;
    logic v_en = 0, i_en = 0, sar_en = 0, aud_en = 0, st_en = 0;
    logic [5:0] v_slot = 0, i_slot = 0, sar_slot = 0, aud_slot = 0, st_slot = 0;
    logic [15:0] v_data = 0, i_data = 0;
    logic sar_len24 = 0, aud_len24 = 0;
    logic [23:0] sar_data = 0, aud_data = 0;
    logic [7:0] st_data = 0;
    logic sdout, sdout_oe, hold_drv;

    int errors = 0, checks = 0;
    int m_cnt = 1023;
    bit m_fs = 0, m_sd = 0, m_oe = 0, m_hold = 0;
    string ph_tag = "R3";
    bit done = 0;

    always #10 clk = ~clk;

    tdm_stream_tx uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (count %0d)", tag, act, exp, m_cnt);
        end
    endtask

    function automatic void own_bit(input int c, output bit hit, output bit b, output string tag);
        int p, st, ln;
        bit e;
        logic [23:0] w;
        hit = 0; b = 0; tag = "R3";
        if (c < int'(bit_off)) return;
        p = c - int'(bit_off);
        for (int k = 0; k < 5; k++) begin
            case (k)
                0: begin e = v_en; st = v_slot * 8;
                       if (iv_mode == 2'b10) begin w = {v_data[15:4], i_data[15:4]}; ln = 24; end
                       else begin w = {v_data, 8'h00}; ln = (iv_mode == 2'b01) ? 8 : 16; end end
                1: begin e = i_en && iv_mode != 2'b10; st = i_slot * 8; w = {i_data, 8'h00};
                       ln = (iv_mode == 2'b01) ? 8 : 16; end
                2: begin e = sar_en; st = sar_slot * 8; w = sar_data; ln = sar_len24 ? 24 : 16; end
                3: begin e = aud_en; st = aud_slot * 8; w = aud_data; ln = aud_len24 ? 24 : 16; end
                default: begin e = st_en; st = st_slot * 8; w = {st_data, 16'h0}; ln = 8; end
            endcase
            if (e && p >= st && p < st + ln) begin
                hit = 1; b = w[23 - (p - st)];
                if (k <= 1 && iv_mode == 2'b10) tag = "R5";
                else if (k <= 1 && iv_mode == 2'b01) tag = "R4";
                return;
            end
        end
    endfunction

    // one bit period: opposite phase then launch phase
    task automatic bit_period(input bit fs);
        bit lvl_launch = !launch_fall;
        bit toggled = (bit_clk != !lvl_launch);
        bit hit, b;
        string tag;
        @(negedge clk);
        bit_clk = !lvl_launch; frame_sync = fs;
        @(negedge clk);
        if (toggled && hold_half && !hold_perm) m_hold = 0;
        chk("R10", hold_drv, m_hold);
        @(negedge clk);
        bit_clk = lvl_launch;
        @(negedge clk);
        if (fs && !m_fs) m_cnt = 0; else if (m_cnt < 1023) m_cnt++;
        m_fs = fs;
        own_bit(m_cnt, hit, b, tag);
        if (hit) begin m_sd = b; m_oe = 1; m_hold = 0; end
        else if (!fill_hiz) begin m_sd = 0; m_oe = 1; m_hold = 0; tag = "R7"; end
        else begin m_hold = hold_en & (hold_perm | m_oe); m_oe = 0; tag = "R8"; end
        chk({tag, "/", ph_tag}, sdout, m_sd);
        chk({tag, "/", ph_tag}, sdout_oe, m_oe);
        chk(hold_perm ? "R11" : "R9", hold_drv, m_hold);
    endtask

    task automatic run_frame(input int len, input int fsw);
        for (int i = 0; i < len; i++) bit_period(i < fsw);
    endtask

    task automatic clear_cfg();
        v_en = 0; i_en = 0; sar_en = 0; aud_en = 0; st_en = 0; iv_mode = 2'b00;
        sar_len24 = 0; aud_len24 = 0; fill_hiz = 0; hold_en = 0; hold_perm = 0; hold_half = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        v_data = 16'hA5C3; i_data = 16'h3C96; sar_data = 24'hF0E1D2;
        aud_data = 24'h8B4D27; st_data = 8'hB6;
        repeat (4) @(negedge clk);
        // R13: reset values
        chk("R13", sdout, 0); chk("R13", sdout_oe, 0); chk("R13", hold_drv, 0);
        rst_n = 1;
        // before any frame start nothing is owned (idle count)
        v_en = 1; v_slot = 0; fill_hiz = 1;
        ph_tag = "R13"; run_frame(4, 0);
        // R2/R3/R7: I2S-like offset, zero fill
        clear_cfg(); bit_off = 1; v_en = 1; v_slot = 0; st_en = 1; st_slot = 3;
        ph_tag = "R2"; run_frame(32, 16); run_frame(32, 16);
        // R4: 8-bit sense
        iv_mode = 2'b01; i_en = 1; i_slot = 1; bit_off = 0;
        ph_tag = "R4"; run_frame(32, 1);
        // R5: packed 12-bit pair, current slot ignored
        iv_mode = 2'b10; v_slot = 1; i_slot = 2; i_en = 1; st_en = 0;
        ph_tag = "R5"; run_frame(32, 1);
        // R6: overlapping streams
        clear_cfg(); sar_en = 1; sar_slot = 0; sar_len24 = 1; v_en = 1; v_slot = 1;
        aud_en = 1; aud_slot = 2; st_en = 1; st_slot = 2; i_en = 1; i_slot = 1;
        ph_tag = "R6"; run_frame(64, 2);
        // R8/R9: release after owned word, one-LSB hold, falling launch (R1)
        clear_cfg(); launch_fall = 1; fill_hiz = 1; hold_en = 1; v_en = 1; v_slot = 1;
        st_en = 1; st_slot = 4; bit_off = 2;
        ph_tag = "R1"; run_frame(64, 3); run_frame(64, 3);
        // R10: half-period hold
        hold_half = 1; ph_tag = "R10"; run_frame(64, 3);
        // R11: permanent hold, then hold disabled
        hold_perm = 1; ph_tag = "R11"; run_frame(64, 3);
        launch_fall = 0; hold_en = 0; run_frame(64, 3);
        // R12: word running past frame end is cut
        clear_cfg(); bit_off = 3; aud_en = 1; aud_slot = 3; aud_len24 = 1; v_en = 1; v_slot = 0;
        ph_tag = "R12"; run_frame(32, 1); run_frame(32, 1);
        fill_hiz = 1; hold_en = 1; run_frame(32, 1); run_frame(32, 1);
        // random mix
        ph_tag = "R3";
        for (int f = 0; f < 40; f++) begin
            int len, nsl;
            len = 32 << $urandom_range(0, 3);
            nsl = len / 8;
            launch_fall = 1'($urandom); bit_off = 3'($urandom); fill_hiz = 1'($urandom);
            hold_en = 1'($urandom); hold_perm = 1'($urandom); hold_half = 1'($urandom);
            iv_mode = 2'($urandom);
            v_en = 1'($urandom); i_en = 1'($urandom); sar_en = 1'($urandom);
            aud_en = 1'($urandom); st_en = 1'($urandom);
            v_slot = 6'($urandom_range(0, nsl)); i_slot = 6'(v_slot + 1);
            sar_slot = 6'($urandom_range(0, nsl)); aud_slot = 6'($urandom_range(0, nsl));
            st_slot = 6'($urandom_range(0, nsl));
            sar_len24 = 1'($urandom); aud_len24 = 1'($urandom);
            v_data = 16'($urandom); i_data = 16'($urandom); sar_data = 24'($urandom);
            aud_data = 24'($urandom); st_data = 8'($urandom);
            run_frame(len, $urandom_range(1, len / 2));
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule